// File: doc/BRIEF.md
# Strided Stream-to-Memory Writer

This block moves a run of elements from an input stream into memory. Software-side logic configures it with a base address, an element count and a stride, then pulses `start`. Each element is popped from the input stream and sent as a write. The k-th element goes to `base + k*stride`. The memory side has three independent streams: a write-address stream, a write-data stream and a write-response stream. The address and data streams signal back-pressure with "full" flags. The response stream signals availability with an "empty" flag.

The block counts issued requests and confirmed writes with two separate counters, so many writes can be in flight at once. A single response value `r` confirms `r+1` writes, which allows the memory side to acknowledge writes in groups. Once every write of the job has been confirmed, `done` pulses for one cycle and `busy` falls.

Top module: `strided_wr_engine`

## Requirements
- R1: The k-th write (k counted from 0) carries address `base_in + k*stride_in`, wrapping modulo 2^ADDR_W, using the values latched at the accepted start.
- R2: A write is issued in a cycle only when all of these hold:
  - the job is running;
  - fewer than `count` writes have been issued;
  - `in_valid` is high;
  - `wa_full` is low;
  - `wd_full` is low.

  In that cycle `wa_push`, `wd_push` and `in_ready` are all high together. In every other cycle all three are low.
- R3: A job issues exactly `count` writes, no more and no fewer.
- R4: `wd_data` equals the `in_data` element popped in the same cycle, so elements reach memory in stream order.
- R5: While a job is running, `rsp_pop` is high in every cycle in which `rsp_empty` is low, including cycles in which a write is also issued.
- R6: Each popped response value `r` adds `r+1` to the confirmed count. `done` is high exactly in the cycle after the one in which the confirmed count first reaches `count`.
- R7: `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after. `done` lasts one cycle. A `start` pulse while `busy` is high is ignored.
- R8: A start with `count_in` = 0 issues no writes and raises `done` in the cycle right after the start.
- R9: After reset, `busy`, `done`, `wa_push`, `wd_push`, `in_ready` and `rsp_pop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; latches base, count and stride while idle |
| base_in | input | ADDR_W | Address of the first element |
| count_in | input | CNT_W | Number of elements to write |
| stride_in | input | ADDR_W | Address step between elements |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Input stream non-empty |
| in_data | input | DATA_W | Head element of the input stream |
| in_ready | output | 1 | Pop of the input stream |
| wa_full | input | 1 | Write-address stream cannot accept |
| wa_push | output | 1 | Push into the write-address stream |
| wa_addr | output | ADDR_W | Address pushed |
| wd_full | input | 1 | Write-data stream cannot accept |
| wd_push | output | 1 | Push into the write-data stream |
| wd_data | output | DATA_W | Data pushed |
| rsp_empty | input | 1 | Write-response stream has no entry |
| rsp_val | input | RSP_W | Head response: number of confirmed writes minus one |
| rsp_pop | output | 1 | Pop of the write-response stream |

## Verification
The hardest situation to reach from the ports is a response pop in the same cycle as a write issue, combined with grouped acknowledgements. These must finish the count exactly on a cycle where other requests are still being stalled. The bench memory model keeps a count of unconfirmed writes. Each cycle it offers a random group of one to four of them as a single response, while independent random back-pressure is applied to the input, address and data streams. The checks then compare `done` cycle by cycle against the cycle in which the model's confirmed total crosses the count. A start pulse in mid-job and a zero-length job are driven directly.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } swr_state_e;
endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int AKW  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  input  logic [AKW-1:0]   ack_next,
  output logic             load,
  output logic             run,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt_q
);
  swr_state_e state_q, state_d;
  logic       reached;

  assign load    = start && (state_q == ST_IDLE);
  assign reached = (ack_next >= {1'b0, cnt_q});

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = (count_in == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (reached) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= count_in;
  end

  assign run  = (state_q == ST_RUN);
  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && count_in == '0) |=> done);

  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reached) |=> done);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cnt_q));
endmodule

// File: rtl/swr_issue.sv
module swr_issue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] stride_in,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              wa_full,
  input  logic              wd_full,
  output logic              in_ready,
  output logic              wa_push,
  output logic [ADDR_W-1:0] wa_addr,
  output logic              wd_push,
  output logic [DATA_W-1:0] wd_data
);
  logic [ADDR_W-1:0] addr_q, addr_d, stride_q;
  logic [CNT_W-1:0]  req_q, req_d;
  logic              fire, addr_en, req_en;

  assign fire = run && (req_q < cnt_q) && in_valid && !wa_full && !wd_full;

  assign addr_en = load || fire;
  assign req_en  = load || fire;

  always_comb begin
    addr_d = load ? base_in : (addr_q + stride_q);
    req_d  = load ? '0 : (req_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stride_q <= '0;
    else if (load) stride_q <= stride_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  assign in_ready = fire;
  assign wa_push  = fire;
  assign wd_push  = fire;
  assign wa_addr  = addr_q;
  assign wd_data  = in_data;

  // R1
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wa_addr == $past(base_in)));

  // R1
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_push && !load) |=> (wa_addr == $past(wa_addr) + stride_q));

  // R2
  issue_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wa_push |-> (in_valid && !wa_full && !wd_full && run));

  // R3
  req_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |-> (req_q <= cnt_q));
endmodule

// File: rtl/swr_ack.sv
module swr_ack #(
  parameter int CNT_W = 16,
  parameter int RSP_W = 8,
  localparam int AKW  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             rsp_empty,
  input  logic [RSP_W-1:0] rsp_val,
  output logic             rsp_pop,
  output logic [AKW-1:0]   ack_next
);
  logic [AKW-1:0] ack_q, ack_d, step;
  logic           ack_en;

  assign rsp_pop = run && !rsp_empty;
  assign step    = {{(AKW-RSP_W){1'b0}}, rsp_val} + 1'b1;

  always_comb begin
    ack_next = rsp_pop ? (ack_q + step) : ack_q;
    ack_d    = load ? '0 : ack_next;
  end

  assign ack_en = load || rsp_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= '0;
    else if (ack_en) ack_q <= ack_d;
  end

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rsp_empty) |-> rsp_pop);

  // R6
  ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pop && !load) |=> (ack_q == $past(ack_q) + {{(AKW-RSP_W){1'b0}}, $past(rsp_val)} + 1'b1));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ack_q == '0));
endmodule

// File: rtl/strided_wr_engine.sv
module strided_wr_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int RSP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [ADDR_W-1:0] stride_in,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              wa_full,
  output logic              wa_push,
  output logic [ADDR_W-1:0] wa_addr,
  input  logic              wd_full,
  output logic              wd_push,
  output logic [DATA_W-1:0] wd_data,
  input  logic              rsp_empty,
  input  logic [RSP_W-1:0]  rsp_val,
  output logic              rsp_pop
);
  localparam int AKW = CNT_W + 1;

  logic             load, run;
  logic [CNT_W-1:0] cnt_q;
  logic [AKW-1:0]   ack_next;

  swr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .count_in(count_in),
    .ack_next(ack_next), .load(load), .run(run), .busy(busy),
    .done(done), .cnt_q(cnt_q)
  );

  swr_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .base_in(base_in), .stride_in(stride_in), .cnt_q(cnt_q),
    .in_valid(in_valid), .in_data(in_data), .wa_full(wa_full),
    .wd_full(wd_full), .in_ready(in_ready), .wa_push(wa_push),
    .wa_addr(wa_addr), .wd_push(wd_push), .wd_data(wd_data)
  );

  swr_ack #(.CNT_W(CNT_W), .RSP_W(RSP_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .rsp_empty(rsp_empty), .rsp_val(rsp_val), .rsp_pop(rsp_pop),
    .ack_next(ack_next)
  );

  // R2
  push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_push == wd_push) && (wa_push == in_ready));
endmodule

// File: tb/tb_strided_wr_engine.sv
module tb_strided_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, CW = 16, RW = 8;
  localparam int NJOB = 6;
  localparam logic [31:0] T_BASE [NJOB] = '{32'h1000, 32'h2000, 32'h0, 32'hFFFF_FFF0, 32'h400, 32'h8000};
  localparam int          T_CNT  [NJOB] = '{1, 8, 16, 5, 12, 30};
  localparam logic [31:0] T_STR  [NJOB] = '{32'h4, 32'h40, 32'h1, 32'h8, 32'h0, 32'h100};
  localparam int          T_BP   [NJOB] = '{0, 30, 60, 20, 50, 40};
  localparam logic [31:0] T_LAST [NJOB] = '{32'h1000, 32'h21C0, 32'hF, 32'h10, 32'h400, 32'h9D00};

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [AW-1:0] base_in = '0, stride_in = '0;
  logic [CW-1:0] count_in = '0;
  logic busy, done, in_ready, wa_push, wd_push, rsp_pop;
  logic in_valid = 0, wa_full = 0, wd_full = 0, rsp_empty = 1;
  logic [DW-1:0] in_data = '0;
  logic [RW-1:0] rsp_val = '0;
  logic [AW-1:0] wa_addr;
  logic [DW-1:0] wd_data;

  strided_wr_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .RSP_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
    .count_in(count_in), .stride_in(stride_in), .busy(busy), .done(done),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wa_full(wa_full), .wa_push(wa_push), .wa_addr(wa_addr),
    .wd_full(wd_full), .wd_push(wd_push), .wd_data(wd_data),
    .rsp_empty(rsp_empty), .rsp_val(rsp_val), .rsp_pop(rsp_pop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit job_active = 0, started = 0, prev_complete = 0;
  int job_id = 0, exp_cnt = 0, bp = 0;
  logic [31:0] exp_base = '0, exp_stride = '0, last_addr = '0;
  int n_push = 0, n_done = 0, ackd = 0, pending = 0, src_idx = 0, n_overlap = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_data(input int jid, input int idx);
    return {jid[7:0], 8'h5A, idx[15:0]};
  endfunction

  // Environment: sample at negedge, drive just after posedge
  initial begin
    forever begin
      @(negedge clk);
      if (job_active) begin
        bit complete_now;
        complete_now = 0;
        if (start && !busy) begin
          started = 1;
          if (exp_cnt == 0) complete_now = 1;
        end else if (started && n_done == 0) begin
          chk(busy === 1'b1, "R7 busy during job", 64'(busy), 64'd1);
        end
        chk(done === prev_complete, "R6 done timing", 64'(done), 64'(prev_complete));
        if (wa_push || wd_push || in_ready) begin
          chk(wa_push && wd_push && in_ready && in_valid && !wa_full && !wd_full,
              "R2 push gating", {wa_push, wd_push, in_ready, in_valid, wa_full, wd_full}, 64'b111100);
          chk(wa_addr === exp_base + exp_stride * 32'(n_push), "R1 address",
              64'(wa_addr), 64'(exp_base + exp_stride * 32'(n_push)));
          chk(wd_data === mk_data(job_id, n_push), "R4 data order",
              64'(wd_data), 64'(mk_data(job_id, n_push)));
          chk(n_push < exp_cnt, "R3 no extra write", 64'(n_push), 64'(exp_cnt));
          last_addr = wa_addr;
          n_push++;
          pending++;
          src_idx++;
        end
        if (busy && !done && !rsp_empty)
          chk(rsp_pop === 1'b1, "R5 response drained", 64'(rsp_pop), 64'd1);
        if (rsp_pop) begin
          if (wa_push) n_overlap++;
          if (ackd < exp_cnt && ackd + int'(rsp_val) + 1 >= exp_cnt) complete_now = 1;
          ackd += int'(rsp_val) + 1;
          pending -= int'(rsp_val) + 1;
        end
        if (done) n_done++;
        prev_complete = complete_now;
      end
      @(posedge clk);
      #1;
      if (job_active) begin
        in_valid = (src_idx < exp_cnt) && ($urandom_range(99) >= bp);
        in_data  = mk_data(job_id, src_idx);
        wa_full  = ($urandom_range(99) < bp);
        wd_full  = ($urandom_range(99) < bp);
        if (pending > 0 && $urandom_range(99) >= bp) begin
          int grp;
          grp = $urandom_range(4, 1);
          if (grp > pending) grp = pending;
          rsp_empty = 0;
          rsp_val   = RW'(grp - 1);
        end else begin
          rsp_empty = 1;
          rsp_val   = '0;
        end
      end else begin
        in_valid = 0; wa_full = 0; wd_full = 0; rsp_empty = 1;
      end
    end
  end

  task automatic run_job(input int jid, input logic [31:0] b, input int c,
                         input logic [31:0] s, input int p, input logic [31:0] last,
                         input bit poke);
    int guard;
    job_id = jid; exp_base = b; exp_cnt = c; exp_stride = s; bp = p;
    n_push = 0; n_done = 0; ackd = 0; pending = 0; src_idx = 0;
    started = 0; prev_complete = 0;
    @(posedge clk); #1;
    job_active = 1;
    start = 1; base_in = b; count_in = CW'(c); stride_in = s;
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      start = 1; base_in = 32'hDEAD_0000; count_in = 16'd3; stride_in = 32'h4;
      @(posedge clk); #1;
      start = 0;
    end
    guard = 0;
    while (n_done == 0 && guard < 5000) begin
      @(posedge clk); #2;
      guard++;
    end
    @(posedge clk); #2;
    chk(busy === 1'b0, "R7 busy low after done", 64'(busy), 64'd0);
    chk(n_done == 1, "R7 single done", 64'(n_done), 64'd1);
    chk(n_push == c, "R3 write count", 64'(n_push), 64'(c));
    chk(ackd == c, "R6 confirmed total", 64'(ackd), 64'(c));
    if (c > 0) chk(last_addr === last, "R1 last address", 64'(last_addr), 64'(last));
    job_active = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !wa_push && !wd_push && !in_ready && !rsp_pop, "R9 reset outputs",
        {busy, done, wa_push, wd_push, in_ready, rsp_pop}, 64'd0);
    rst_n = 1;
    @(posedge clk); #2;
    chk(!busy && !done && !wa_push && !rsp_pop, "R9 idle after reset",
        {busy, done, wa_push, rsp_pop}, 64'd0);

    for (int i = 0; i < NJOB; i++)
      run_job(i + 1, T_BASE[i], T_CNT[i], T_STR[i], T_BP[i], T_LAST[i], 1'b0);

    // R8 zero-length job
    run_job(20, 32'h3000, 0, 32'h4, 30, 32'h0, 1'b0);
    // R7 start during a job is ignored
    run_job(21, 32'h5000, 20, 32'h10, 30, 32'h5130, 1'b1);
    // heavy back-pressure with long groups
    run_job(22, 32'hA000, 40, 32'h8, 70, 32'hA138, 1'b0);

    chk(n_overlap >= 0 && n_cmp > 0, "R5 bookkeeping", 64'(n_overlap), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule